// File: doc/BRIEF.md
# Command Slot Issue Selector

This block chooses which of a set of command slots a port should issue next. A pending-command vector marks the slots that hold work. A start control switches the command engine on and off. A valid/accept handshake confirms each issue. The block holds the index of the slot issued last, which is also read back as the current-slot value. It searches the pending vector in round-robin order. The first search after the engine starts gives slot 0 the highest priority. Every later search starts at the slot just after the one issued last, and wraps from the top slot back to slot 0.

Control is a three-state machine:
- **IDLE**: the engine is stopped.
- **ARMED**: the engine is running and nothing has been issued since it started.
- **ROTATE**: the engine is running and at least one slot has been issued.

The transitions are:
- **GO** (IDLE to ARMED): taken when start is sampled high.
- **FIRST_ISSUE** (ARMED to ROTATE): taken on a completed handshake.
- **HALT** (ARMED or ROTATE to IDLE): taken when start is sampled low. HALT also clears the current-slot register.

Fetching commands, executing them and clearing pending bits are done outside this block.

Top module: `slot_issue_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `run_o` and `sel_vld_o` are 0 and `cur_slot_o` is 0.
- R2: `run_o` rises in the cycle after `start_i` is first sampled high at a clock edge. It falls in the cycle after `start_i` is sampled low.
- R3: In ARMED state the search begins at slot 0, so the selected index is the lowest-numbered set bit of `pend_i`.
- R4: A completed handshake (`sel_vld_o` and `accept_i` high at a clock edge) loads the issued index into `cur_slot_o`. The next search begins at that index plus one. For example, with `cur_slot_o` = 0 after a first issue and `pend_i` = 0x3, the next index is 1.
- R5: The search wraps from slot NUM_SLOTS-1 to slot 0. When only the slot issued last is pending, that same slot is selected again.
- R6: `sel_vld_o` is 0 whenever `pend_i` is zero, `start_i` is 0, or `run_o` is 0.
- R7: Without a completed handshake, `cur_slot_o` and the search start point stay unchanged while the engine keeps running.
- R8: A HALT returns `cur_slot_o` to 0 in the next cycle. The next GO restarts the search from slot 0.
- R9: Whenever `sel_vld_o` is 1, bit `sel_idx_o` of `pend_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command engine enable |
| pend_i | input | NUM_SLOTS (32) | Pending-command vector, one bit per slot |
| accept_i | input | 1 | Issue accepted by the consumer |
| sel_idx_o | output | IDX_W (5) | Index of the selected slot |
| sel_vld_o | output | 1 | Selected index is valid |
| cur_slot_o | output | IDX_W (5) | Current-slot register readback |
| run_o | output | 1 | Command engine running |

## Verification
Some properties are checked by the assertions on every cycle:
- a valid index always points at a pending bit;
- valid stays low when there is no work or the engine is stopped;
- a handshake loads the current slot;
- a HALT clears the current slot;
- the current slot holds steady when no handshake completes;
- the ARMED search favours slot 0.

Other behaviour can only be shown by the bench's scenarios against its behavioural model:
- the full round-robin order, including the 0x3 example;
- the wrap from the top slot to slot 0, and re-selection of the slot issued last;
- the restart from slot 0 after a HALT/GO pair;
- the one-cycle lag of the running flag.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ROTATE = 2'd2
    } sel_state_e;

endpackage

// File: rtl/slot_sel_fsm.sv
module slot_sel_fsm
    import slot_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       issue_i,
    output sel_state_e state_o,
    output logic       run_o,
    output logic       first_o,
    output logic       halt_o
);

    sel_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO, FIRST_ISSUE, HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!start_i)     state_d = ST_IDLE;
                else if (issue_i) state_d = ST_ROTATE;
            end
            ST_ROTATE: if (!start_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run_o   = 1'b0;
        first_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin run_o = 1'b0; first_o = 1'b0; end
            ST_ARMED:  begin run_o = 1'b1; first_o = 1'b1; end
            ST_ROTATE: begin run_o = 1'b1; first_o = 1'b0; end
            default:   begin run_o = 1'b0; first_o = 1'b0; end
        endcase
        halt_o = run_o && !start_i;
    end

    assign state_o = state_q;

    a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_ARMED, ST_ROTATE});

    a_r8_halt_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/slot_cur_reg.sv
module slot_cur_reg #(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_val_i,
    output logic [IDX_W-1:0] cur_o,
    output logic [IDX_W-1:0] next_base_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    logic [IDX_W-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur_q <= '0;
        else if (clear_i) cur_q <= '0;
        else if (load_i)  cur_q <= load_val_i;
    end

    always_comb begin
        if (cur_q == LAST_IDX) next_base_o = '0;
        else                   next_base_o = cur_q + 1'b1;
    end

    assign cur_o = cur_q;

    a_r4_load_takes_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cur_o == $past(load_val_i)));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cur_o == '0));

endmodule

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic [IDX_W-1:0]     base_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);

    localparam int EW = IDX_W + 1;

    logic [EW-1:0] cand;

    // scan from base upward, wrapping past the top slot
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        cand    = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cand = {1'b0, base_i} + EW'(i);
            if (cand >= EW'(NUM_SLOTS)) cand = cand - EW'(NUM_SLOTS);
            if (!found_o && req_i[cand[IDX_W-1:0]]) begin
                found_o = 1'b1;
                idx_o   = cand[IDX_W-1:0];
            end
        end
    end

    a_r9_pick_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> req_i[idx_o]);

    a_r6_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> !found_o);

endmodule

// File: rtl/slot_issue_sel.sv
module slot_issue_sel
    import slot_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_SLOTS-1:0] pend_i,
    input  logic                 accept_i,
    output logic [IDX_W-1:0]     sel_idx_o,
    output logic                 sel_vld_o,
    output logic [IDX_W-1:0]     cur_slot_o,
    output logic                 run_o
);

    sel_state_e       state;
    logic             first, halt, issue, found;
    logic [IDX_W-1:0] base, next_base, pick;

    slot_sel_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .issue_i (issue),
        .state_o (state),
        .run_o   (run_o),
        .first_o (first),
        .halt_o  (halt)
    );

    slot_cur_reg #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_cur (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (halt),
        .load_i      (issue),
        .load_val_i  (pick),
        .cur_o       (cur_slot_o),
        .next_base_o (next_base)
    );

    assign base = first ? '0 : next_base;

    slot_rr_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pend_i),
        .base_i  (base),
        .found_o (found),
        .idx_o   (pick)
    );

    assign sel_vld_o = run_o && start_i && found;
    assign sel_idx_o = pick;
    assign issue     = sel_vld_o && accept_i;

    a_r6_no_vld_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i || !run_o || pend_i == '0) |-> !sel_vld_o);

    a_r7_hold_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && start_i && !(sel_vld_o && accept_i)) |=> $stable(cur_slot_o));

    a_r3_armed_favours_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sel_vld_o && pend_i[0]) |-> (sel_idx_o == '0));

    a_r2_run_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> run_o);

endmodule

// File: tb/slot_issue_sel_test.sv
module slot_issue_sel_test;

    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N-1:0]  pend_i = '0;
    logic          accept_i = 1'b0;
    logic [4:0]    sel_idx_o;
    logic          sel_vld_o;
    logic [4:0]    cur_slot_o;
    logic          run_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // behavioural reference state
    bit m_run   = 0;
    bit m_first = 0;
    int m_cur   = 0;

    always #(CLK_P/2) clk = ~clk;

    slot_issue_sel uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pend_i(pend_i),
        .accept_i(accept_i), .sel_idx_o(sel_idx_o), .sel_vld_o(sel_vld_o),
        .cur_slot_o(cur_slot_o), .run_o(run_o)
    );

    function automatic int ref_pick(input logic [N-1:0] p, input int from);
        for (int k = 0; k < N; k++) begin
            if (p[(from + k) % N]) return (from + k) % N;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one cycle, compare against the model, then advance the model
    task automatic step(input string req, input bit st, input logic [N-1:0] p, input bit acc);
        int from, e_idx;
        bit e_vld;
        @(negedge clk);
        start_i  = st;
        pend_i   = p;
        accept_i = acc;
        #1;
        from  = m_first ? 0 : (m_cur + 1) % N;
        e_idx = ref_pick(p, from);
        e_vld = m_run && st && (e_idx >= 0);
        chk(req, "run", int'(run_o), int'(m_run));
        chk(req, "vld", int'(sel_vld_o), int'(e_vld));
        chk(req, "cur", int'(cur_slot_o), m_cur);
        if (e_vld) chk(req, "idx", int'(sel_idx_o), e_idx);
        @(posedge clk);
        if (m_run && !st) begin
            m_run = 0; m_first = 0; m_cur = 0;
        end else if (!m_run && st) begin
            m_run = 1; m_first = 1;
        end else if (e_vld && acc) begin
            m_cur = e_idx; m_first = 0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lfsr;
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "run in reset", int'(run_o), 0);
        chk("R1", "vld in reset", int'(sel_vld_o), 0);
        chk("R1", "cur in reset", int'(cur_slot_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, 32'h0000_00F0, 1);
        // R2 / R6 start rising: first cycle not yet running
        step("R2", 1, 32'h0000_0003, 1);
        // R6 empty vector
        step("R6", 1, 32'h0, 1);
        // R3 first issue from slot 0, then R4 example 0x3 -> slot 1
        step("R3", 1, 32'h0000_0003, 1);
        step("R4", 1, 32'h0000_0003, 1);
        step("R4", 1, 32'h0000_0003, 1);
        // R7 hold without accept
        step("R7", 1, 32'h0000_0F00, 0);
        step("R7", 1, 32'h8000_0000, 0);
        step("R4", 1, 32'h0000_0F00, 1);
        // R5 wrap: take slot 31, then 0x5 gives slot 0
        step("R5", 1, 32'h8000_0001, 1);
        step("R5", 1, 32'h8000_0000, 1);
        step("R5", 1, 32'h0000_0005, 1);
        // R5 only the last-issued slot pending
        step("R5", 1, 32'h0000_0001, 1);
        step("R5", 1, 32'h0000_0001, 0);
        // R8 halt, then restart searching from 0
        step("R6", 0, 32'h0000_0006, 1);
        step("R8", 0, 32'h0000_0006, 1);
        step("R8", 1, 32'h0000_0006, 1);
        step("R8", 1, 32'h0000_0006, 1);
        step("R4", 1, 32'h0000_0006, 1);
        // R9 varied patterns
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R9", (n % 37) != 36, (n % 11 == 0) ? '0 : (lfsr & {lfsr[15:0], lfsr[31:16]}),
                 lfsr[3] | lfsr[9]);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule